// File: doc/BRIEF.md
# Page Load and Program Sequencer

This block runs the write side of a one-time-programmable memory once software has asked for a page program. After a start pulse it gathers single-word writes into a 64-word page buffer. Each word write has two phases. The falling edge of the chip select captures the address, and the rising edge captures the data. The word offsets may come in any order. The same offset may be written again, and the last data wins. Every write in one load must name the same page. A write that names a different page aborts the operation and raises a sticky failure flag.

Loading ends by itself. Once a write has finished, a window measured in microsecond ticks is open. If no new write begins before the window runs out, the block enters its programming period. That period is modelled as a fixed number of ticks. At its end the block gives a one-cycle commit pulse. During that pulse the latched page number, the buffer words and their valid bits describe exactly what is to be written into the cells. The block then reports done. A controller reads busy and done the way it would poll a ready status bit. It must clear the failure flag before another program can start.

Top module: `pls_page_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and commit_o are 0, and every bit of buf_valid_o is 0.
- R2: A start_i pulse is accepted only when busy_o is 0 and fail_o is 0. On the next cycle busy_o is 1, done_o is 0 and all valid bits are 0. While the block is idle and start_i is low, buf_valid_o does not change.
- R3: A write is a ce_fall_i pulse, which captures addr_i, followed by a ce_rise_i pulse, which stores data_i. The data goes to word addr_i[5:0], which sits at buf_data_o[16*k+15:16*k], and that word's bit of buf_valid_o is set. Offsets may arrive in any order, and a repeated offset keeps the newest data.
- R4: The first write of a load latches addr_i[19:6] onto page_o.
- R5: During a load, a ce_fall_i whose addr_i[19:6] differs from page_o sets fail_o. On the next cycle busy_o is 0 and all valid bits are 0, and no commit follows.
- R6: Loading ends after LOAD_TMO_US ticks of us_tick_i, counted from the last ce_rise_i with no ce_fall_i between. Ticks that come while a write is open (after ce_fall_i and before ce_rise_i) are not counted. A new ce_fall_i restarts the count.
- R7: The programming period lasts PROG_US ticks, and busy_o stays 1 throughout. After the last tick, commit_o is 1 for exactly one cycle, with done_o 1 and busy_o 0. done_o then stays 1 until the next accepted start.
- R8: While the block is programming, writes and start pulses have no effect on the buffer, on page_o or on busy_o.
- R9: A start_i pulse while fail_o is 1 is ignored, and busy_o stays 0. When the block is idle, fail_clr_i clears fail_o.
- R10: A ce_rise_i pulse with no open write leaves the buffer and the valid bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Page program requested; opens a load |
| ce_fall_i | input | 1 | One-cycle pulse: write begins, address is sampled |
| ce_rise_i | input | 1 | One-cycle pulse: write ends, data is sampled |
| addr_i | input | 20 | Word address: [19:6] page, [5:0] word offset |
| data_i | input | 16 | Write data |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| fail_clr_i | input | 1 | Clears the sticky failure flag while idle |
| busy_o | output | 1 | Load or programming in progress |
| done_o | output | 1 | Last program completed |
| fail_o | output | 1 | Sticky failure flag |
| commit_o | output | 1 | One-cycle pulse at the end of programming |
| page_o | output | 14 | Latched page number |
| buf_data_o | output | 1024 | Page buffer, word k at bits [16k+15:16k] |
| buf_valid_o | output | 64 | Per-word valid bits |

## Verification
The bench builds the block with LOAD_TMO_US set to 4 and PROG_US set to 3, keeping the widths and page size at their defaults. With these small limits, the exact tick that closes the load window and the tick that ends programming each fall within a handful of cycles. This lets the bench probe one tick short of each limit and the tick that reaches it. It also lets the bench show that ticks arriving during an open write and a write restarting the window both move the end of loading. Full 64-word pages and the default microsecond counts change only the counter widths, not the sequencing.

// File: rtl/pls_pkg.sv
package pls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_OPEN  = 3'd2,
        ST_GAP   = 3'd3,
        ST_PROG  = 3'd4
    } pls_state_e;

endpackage

// File: rtl/pls_tick_timer.sv
module pls_tick_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && tick_i && (cnt_q == CW'(LIMIT - 1));
        cnt_d    = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = expire_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pls_page_buf.sv
module pls_page_buf #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    wr_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic [WORDS*DATA_W-1:0] data_o,
    output logic [WORDS-1:0]        valid_o
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DATA_W-1:0] word_d, word_q;
        logic              vld_d, vld_q;
        logic              hit;

        always_comb begin
            hit    = wr_i && (idx_i == IDX_W'(i));
            word_d = hit ? data_i : word_q;
            vld_d  = clr_i ? 1'b0 : (hit ? 1'b1 : vld_q);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                word_q <= word_d;
                vld_q  <= vld_d;
            end
        end

        assign data_o[i*DATA_W +: DATA_W] = word_q;
        assign valid_o[i]                 = vld_q;
    end
endmodule

// File: rtl/pls_ctrl.sv
module pls_ctrl
    import pls_pkg::*;
#(
    parameter int PAGE_W = 14,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic [PAGE_W-1:0] page_in_i,
    input  logic [OFF_W-1:0]  off_in_i,
    input  logic              clr_fail_i,
    input  logic              load_exp_i,
    input  logic              prog_exp_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              commit_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              buf_clr_o,
    output logic              buf_wr_o,
    output logic [OFF_W-1:0]  buf_idx_o,
    output logic              load_run_o,
    output logic              prog_run_o
);
    typedef struct packed {
        pls_state_e        st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic              fail;
        logic              done;
        logic              commit;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d         = q;
        d.commit  = 1'b0;
        buf_clr_o = 1'b0;
        buf_wr_o  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (clr_fail_i) d.fail = 1'b0;
                if (start_i && !q.fail) begin
                    d.st      = ST_ARMED;
                    d.done    = 1'b0;
                    buf_clr_o = 1'b1;
                end
            end
            ST_ARMED: begin
                if (fall_i) begin
                    d.page = page_in_i;
                    d.off  = off_in_i;
                    d.st   = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (rise_i) begin
                    buf_wr_o = 1'b1;
                    d.st     = ST_GAP;
                end
            end
            ST_GAP: begin
                if (fall_i) begin
                    if (page_in_i != q.page) begin
                        d.fail    = 1'b1;
                        d.st      = ST_IDLE;
                        buf_clr_o = 1'b1;
                    end else begin
                        d.off = off_in_i;
                        d.st  = ST_OPEN;
                    end
                end else if (load_exp_i) begin
                    d.st = ST_PROG;
                end
            end
            ST_PROG: begin
                if (prog_exp_i) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.commit = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, page: '0, off: '0, fail: 1'b0, done: 1'b0, commit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign fail_o     = q.fail;
    assign commit_o   = q.commit;
    assign page_o     = q.page;
    assign buf_idx_o  = q.off;
    assign load_run_o = (q.st == ST_GAP);
    assign prog_run_o = (q.st == ST_PROG);
endmodule

// File: rtl/pls_page_seq.sv
module pls_page_seq #(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int WORDS       = 64,
    parameter int LOAD_TMO_US = 100,
    parameter int PROG_US     = 900
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic                           ce_fall_i,
    input  logic                           ce_rise_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              data_i,
    input  logic                           us_tick_i,
    input  logic                           fail_clr_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           fail_o,
    output logic                           commit_o,
    output logic [ADDR_W-$clog2(WORDS)-1:0] page_o,
    output logic [WORDS*DATA_W-1:0]        buf_data_o,
    output logic [WORDS-1:0]               buf_valid_o
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              buf_clr, buf_wr;
    logic [OFF_W-1:0]  buf_idx;
    logic              load_run, prog_run, load_exp, prog_exp;
    logic              prog_act;

    pls_ctrl #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .fall_i     (ce_fall_i),
        .rise_i     (ce_rise_i),
        .page_in_i  (addr_i[ADDR_W-1:OFF_W]),
        .off_in_i   (addr_i[OFF_W-1:0]),
        .clr_fail_i (fail_clr_i),
        .load_exp_i (load_exp),
        .prog_exp_i (prog_exp),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .commit_o   (commit_o),
        .page_o     (page_o),
        .buf_clr_o  (buf_clr),
        .buf_wr_o   (buf_wr),
        .buf_idx_o  (buf_idx),
        .load_run_o (load_run),
        .prog_run_o (prog_run)
    );

    pls_tick_timer #(.LIMIT(LOAD_TMO_US)) load_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (load_run),
        .tick_i   (us_tick_i),
        .expire_o (load_exp)
    );

    pls_tick_timer #(.LIMIT(PROG_US)) prog_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (prog_run),
        .tick_i   (us_tick_i),
        .expire_o (prog_exp)
    );

    pls_page_buf #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(OFF_W)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .wr_i    (buf_wr),
        .idx_i   (buf_idx),
        .data_i  (data_i),
        .data_o  (buf_data_o),
        .valid_o (buf_valid_o)
    );

    assign prog_act = prog_run;
endmodule

// File: rtl/pls_page_seq_chk.sv
module pls_page_seq_chk #(
    parameter int WORDS = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             fail_o,
    input logic             commit_o,
    input logic [WORDS-1:0] buf_valid_o,
    input logic             prog_act
);
    AST_COMMIT_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (done_o && !busy_o)); // R7
    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (!busy_o && (buf_valid_o == '0))); // R5
    AST_FAIL_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !busy_o && start_i) |=> !busy_o); // R9
    AST_IDLE_VALID_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(buf_valid_o)); // R2
    AST_PROG_VALID_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_act |=> $stable(buf_valid_o)); // R8
endmodule

bind pls_page_seq pls_page_seq_chk #(.WORDS(WORDS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .commit_o    (commit_o),
    .buf_valid_o (buf_valid_o),
    .prog_act    (prog_act)
);

// File: tb/pls_page_seq_tb.sv
module pls_page_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO  = 4;
    localparam int PROG = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, ce_fall_i = 1'b0, ce_rise_i = 1'b0;
    logic [19:0]   addr_i = '0;
    logic [15:0]   data_i = '0;
    logic          us_tick_i = 1'b0, fail_clr_i = 1'b0;
    logic          busy_o, done_o, fail_o, commit_o;
    logic [13:0]   page_o;
    logic [1023:0] buf_data_o;
    logic [63:0]   buf_valid_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [13:0]       page;
        logic [63:0]       mask;
        logic [63:0][15:0] data;
    } exp_t;

    exp_t sb_q[$];
    exp_t model;

    always #(CLK_PERIOD/2) clk = ~clk;

    pls_page_seq #(.LOAD_TMO_US(TMO), .PROG_US(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ce_fall_i(ce_fall_i),
        .ce_rise_i(ce_rise_i), .addr_i(addr_i), .data_i(data_i),
        .us_tick_i(us_tick_i), .fail_clr_i(fail_clr_i), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .commit_o(commit_o), .page_o(page_o),
        .buf_data_o(buf_data_o), .buf_valid_o(buf_valid_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_fall(input logic [13:0] pg, input logic [5:0] off);
        addr_i = {pg, off}; ce_fall_i = 1'b1; step(); ce_fall_i = 1'b0;
    endtask

    task automatic do_rise(input logic [15:0] dat);
        data_i = dat; ce_rise_i = 1'b1; step(); ce_rise_i = 1'b0;
    endtask

    // driver: write a word and record it in the expected page when accepted
    task automatic wr_word(input logic [13:0] pg, input logic [5:0] off,
                           input logic [15:0] dat, input bit accept);
        do_fall(pg, off);
        do_rise(dat);
        if (accept) begin
            model.page      = pg;
            model.mask[off] = 1'b1;
            model.data[off] = dat;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick_i = 1'b1; step(); us_tick_i = 1'b0; step();
        end
    endtask

    task automatic do_start();
        start_i = 1'b1; step(); start_i = 1'b0;
        model = '0;
    endtask

    // monitor: pop one expected page per commit pulse
    always @(negedge clk) begin
        if (rst_n && commit_o) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected commit actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R4 committed page", 64'(page_o), 64'(e.page));
                chk("R3 committed valid mask", buf_valid_o, e.mask);
                for (int i = 0; i < 64; i++) begin
                    if (e.mask[i]) chk("R3 committed word data", 64'(buf_data_o[i*16 +: 16]), 64'(e.data[i]));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [13:0] pg1, pg2;
        logic [63:0] mask_now;
        pg1 = 14'h2A5;
        pg2 = 14'h1C3;
        model = '0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 busy after reset", 64'(busy_o), 64'd0);
        chk("R1 done after reset", 64'(done_o), 64'd0);
        chk("R1 fail after reset", 64'(fail_o), 64'd0);
        chk("R1 valid after reset", buf_valid_o, 64'd0);

        do_start();
        chk("R2 busy after start", 64'(busy_o), 64'd1);

        wr_word(pg1, 6'd63, 16'hA001, 1'b1);
        chk("R4 page latched on first write", 64'(page_o), 64'(pg1));
        wr_word(pg1, 6'd0,  16'hA002, 1'b1);
        wr_word(pg1, 6'd17, 16'hA003, 1'b1);
        wr_word(pg1, 6'd17, 16'hA004, 1'b1);
        wr_word(pg1, 6'd5,  16'hA005, 1'b1);
        chk("R3 valid bits scattered order", buf_valid_o, model.mask);
        chk("R3 rewrite keeps newest data", 64'(buf_data_o[17*16 +: 16]), 64'h0A004);

        // ticks during an open write do not close the window
        do_fall(pg1, 6'd9);
        ticks(TMO + 2);
        chk("R6 still loading after ticks with write open", 64'(busy_o), 64'd1);
        do_rise(16'hA006);
        model.mask[9] = 1'b1; model.data[9] = 16'hA006;
        chk("R6 write accepted after open-write ticks", 64'(buf_valid_o[9]), 64'd1);

        // stray rise with no open write
        mask_now = buf_valid_o;
        do_rise(16'hFFFF);
        chk("R10 stray rise leaves valid bits", buf_valid_o, mask_now);

        // window restarts on a new write
        ticks(TMO - 1);
        wr_word(pg1, 6'd40, 16'hA007, 1'b1);
        chk("R6 write accepted before timeout", 64'(buf_valid_o[40]), 64'd1);
        ticks(TMO - 1);
        chk("R6 no program one tick short", 64'(done_o), 64'd0);
        sb_q.push_back(model);
        ticks(1);

        // now programming: writes and start are ignored
        mask_now = buf_valid_o;
        wr_word(pg1, 6'd1, 16'hBEEF, 1'b0);
        do_start();
        chk("R8 write ignored while programming", buf_valid_o, mask_now);
        chk("R8 page held while programming", 64'(page_o), 64'(pg1));
        ticks(PROG - 1);
        chk("R7 busy one tick short of end", 64'(busy_o), 64'd1);
        chk("R7 done low one tick short of end", 64'(done_o), 64'd0);
        ticks(1);
        chk("R7 done after programming", 64'(done_o), 64'd1);
        chk("R7 busy low after programming", 64'(busy_o), 64'd0);
        chk("R7 commit is one cycle", 64'(commit_o), 64'd0);

        // page mismatch aborts
        do_start();
        chk("R2 done cleared by start", 64'(done_o), 64'd0);
        chk("R2 valid cleared by start", buf_valid_o, 64'd0);
        wr_word(pg2, 6'd2, 16'hC001, 1'b0);
        wr_word(pg2, 6'd3, 16'hC002, 1'b0);
        do_fall(pg2 + 14'd1, 6'd4);
        chk("R5 fail on page mismatch", 64'(fail_o), 64'd1);
        chk("R5 busy low after abort", 64'(busy_o), 64'd0);
        chk("R5 valid cleared after abort", buf_valid_o, 64'd0);
        do_rise(16'hC003);
        ticks(TMO + PROG + 2);
        chk("R5 no commit after abort", 64'(sb_q.size()), 64'd0);

        // fail blocks start until cleared
        do_start();
        chk("R9 start ignored while failed", 64'(busy_o), 64'd0);
        fail_clr_i = 1'b1; step(); fail_clr_i = 1'b0;
        chk("R9 fail cleared", 64'(fail_o), 64'd0);
        do_start();
        chk("R9 start accepted after clear", 64'(busy_o), 64'd1);
        wr_word(pg2, 6'd31, 16'hD00D, 1'b1);
        sb_q.push_back(model);
        ticks(TMO);
        ticks(PROG);
        chk("R7 second program done", 64'(done_o), 64'd1);
        chk("R7 all commits seen", 64'(sb_q.size()), 64'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule